// File: doc/BRIEF.md
# Clock Generator Output-Enable Register Bank

This block is a write-only two-wire serial slave. It holds the control registers of a clock generator with many outputs. It watches SCL and SDA with an oversampling system clock, and it recognises its own 7-bit address only when the direction bit asks for a write. It acknowledges that address and every data byte that follows by pulling SDA low. The first data bytes of each transfer are thrown away. The bytes after them go to three 8-bit control registers.

The registers hold three kinds of control:
- Output-enable bits for the CPU pairs, AGP, USB and reference outputs.
- Output-enable bits for the PCI outputs and the second reference output.
- A mode byte with spread-spectrum enable, three frequency-select bits, a select bit for the configuration source, and the SDRAM-output enable.

The frequency-select bits are muxed with three strap pins. The select bit in the mode byte decides whether the effective selection comes from the register or from the straps. Written bytes wait in shadow storage and reach the outputs only when a STOP is seen. A transfer that is cut short therefore never leaves a half-written value on the outputs.

Top module: `clkgen_ctl_bank`

## Requirements
- R1: After reset the three registers read as follows, and SDA is released:
  - `out_en_a` = 8'hFF
  - `out_en_b` = 8'hFF
  - `mode_ctl` = 8'h7D
- R2: An address byte equal to 7'h69 (sent most significant bit first), followed by a direction bit of 0, is acknowledged: SDA is held low during the 9th SCL pulse. The drive starts only after an SCL falling edge.
- R3: An address byte with a different address, or with a direction bit of 1, is not acknowledged. The slave then acknowledges no further byte and changes no register until the next START.
- R4: Every complete data byte of an addressed write is acknowledged. The first bit received is bit 7.
- R5: Data bytes 0 to 3 of a transfer change no register, whatever their values.
- R6: Data bytes 4, 5 and 6 load `out_en_a`, `out_en_b` and `mode_ctl` respectively. Bytes beyond 6 are acknowledged and have no effect on any register.
- R7: Register outputs change only in the cycle after a STOP is detected. A data byte whose bits are not all received before STOP changes nothing.
- R8: A repeated START restarts the data byte count at 0.
- R9: The effective frequency select `freq_sel_eff` = {test, fs1, fs0} follows these rules:
  - When `mode_ctl` bit 1 is 1, it equals `mode_ctl[6:4]`, with bit 6 as test, bit 5 as fs1 and bit 4 as fs0.
  - When `mode_ctl` bit 1 is 0, it equals {`strap_test`, `strap_fs1`, `strap_fs0`}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_drive_low | output | 1 | Open-drain pull-down request for SDA (acknowledge) |
| strap_test | input | 1 | Strap value for the test-mode select |
| strap_fs1 | input | 1 | Strap value for frequency select bit 1 |
| strap_fs0 | input | 1 | Strap value for frequency select bit 0 |
| out_en_a | output | 8 | Enables for reference, USB and AGP outputs and the CPU pairs |
| out_en_b | output | 8 | Enables for the second reference output and the PCI outputs |
| mode_ctl | output | 8 | Spread enable, register frequency select, source select, SDRAM enable |
| freq_sel_eff | output | 3 | Effective {test, fs1, fs0} after the source mux |

## Verification
The hardest case to reach is a repeated START in the middle of a transfer that has already passed some data bytes. A byte count that fails to clear there shows up only as a value loaded into the wrong register. The bench drives a second address phase without a STOP after two data bytes. It then sends a run of bytes whose values differ in every position, so a miscounted index shows up as a wrong register value. A STOP that arrives partway through a byte is produced by a bit-level driver that can end a transfer after any number of bits. Between STOPs, a reference model compared on every clock shows that nothing leaks to the outputs early.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_SKIP = 2'd3
  } link_state_t;

  localparam int unsigned REG_COUNT = 3;

  // Power-up value of each control register, indexed from the first loaded byte.
  function automatic logic [7:0] reset_value(input int unsigned idx);
    case (idx)
      0:       return 8'hFF;
      1:       return 8'hFF;
      default: return 8'h7D;
    endcase
  endfunction

  // Address byte selects this slave for a write.
  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
    return (b[7:1] == dev) && !b[0];
  endfunction

  // Register-driven or strap-driven frequency selection.
  function automatic logic [2:0] pick_freq(input logic [7:0] mode, input logic [2:0] strap);
    return mode[1] ? mode[6:4] : strap;
  endfunction

endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic scl_q;
  logic sda_q;
  logic scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_raw};
      sda_ff <= {sda_ff[STAGES-2:0], sda_raw};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/byte_rx.sv
module byte_rx
  import clkctl_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  parameter int unsigned IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_s,
  input  logic             start_evt,
  input  logic             stop_evt,
  output logic             sda_drive_low,
  output logic             byte_evt,
  output logic [7:0]       byte_data,
  output logic [IDX_W-1:0] byte_idx,
  output logic             ignoring
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  link_state_t      st;
  logic [7:0]       shreg;
  logic [3:0]       nbits;
  logic             ack_on;
  logic             evt_q;
  logic [IDX_W-1:0] idx;
  logic             byte_full;
  logic             active;

  assign byte_full = (nbits == 4'd8);
  assign active    = (st == ST_ADDR) || (st == ST_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      shreg  <= '0;
      nbits  <= '0;
      ack_on <= 1'b0;
      evt_q  <= 1'b0;
      idx    <= '0;
    end else begin
      evt_q <= 1'b0;
      if (start_evt) begin
        st     <= ST_ADDR;
        nbits  <= '0;
        ack_on <= 1'b0;
        idx    <= '0;
      end else if (stop_evt) begin
        st     <= ST_IDLE;
        nbits  <= '0;
        ack_on <= 1'b0;
      end else if (active) begin
        if (scl_rise && !byte_full) begin
          shreg <= {shreg[6:0], sda_s};
          nbits <= nbits + 4'd1;
        end else if (scl_fall && ack_on) begin
          // end of the acknowledge pulse
          ack_on <= 1'b0;
          nbits  <= '0;
          if (st == ST_ADDR) begin
            st <= ST_DATA;
          end else if (idx != IDX_MAX) begin
            idx <= idx + IDX_W'(1);
          end
        end else if (scl_fall && byte_full) begin
          if (st == ST_ADDR) begin
            if (addr_hit(shreg, DEV_ADDR)) begin
              ack_on <= 1'b1;
            end else begin
              st <= ST_SKIP;
            end
          end else begin
            ack_on <= 1'b1;
            evt_q  <= 1'b1;
          end
        end
      end
    end
  end

  assign sda_drive_low = ack_on;
  assign byte_evt      = evt_q;
  assign byte_data     = shreg;
  assign byte_idx      = idx;
  assign ignoring      = (st == ST_SKIP);
endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import clkctl_pkg::*;
#(
  parameter int unsigned SKIP  = 4,
  parameter int unsigned IDX_W = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       byte_evt,
  input  logic [7:0]                 byte_data,
  input  logic [IDX_W-1:0]           byte_idx,
  input  logic                       commit,
  output logic [REG_COUNT-1:0][7:0]  live
);
  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(SKIP + g);
    localparam logic [7:0]       RST_V  = reset_value(g);
    logic [7:0] shadow;
    logic [7:0] held;
    logic       pend;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow <= RST_V;
        held   <= RST_V;
        pend   <= 1'b0;
      end else if (byte_evt && byte_idx == MY_IDX) begin
        shadow <= byte_data;
        pend   <= 1'b1;
      end else if (commit && pend) begin
        held <= shadow;
        pend <= 1'b0;
      end
    end

    assign live[g] = held;
  end
endmodule

// File: rtl/clkgen_ctl_bank.sv
module clkgen_ctl_bank
  import clkctl_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h69,
  parameter int unsigned SKIP_BYTES  = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_drive_low,
  input  logic       strap_test,
  input  logic       strap_fs1,
  input  logic       strap_fs0,
  output logic [7:0] out_en_a,
  output logic [7:0] out_en_b,
  output logic [7:0] mode_ctl,
  output logic [2:0] freq_sel_eff
);
  localparam int unsigned IDX_W = $clog2(SKIP_BYTES + REG_COUNT + 1);

  // named internal events, also observed by the bound checker
  logic                      sda_s;
  logic                      scl_rise_evt;
  logic                      scl_fall_evt;
  logic                      start_evt;
  logic                      stop_evt;
  logic                      byte_evt;
  logic [7:0]                byte_data;
  logic [IDX_W-1:0]          byte_idx;
  logic                      ignoring;
  logic [REG_COUNT-1:0][7:0] live;

  bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_raw   (scl_in),
    .sda_raw   (sda_in),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise_evt),
    .scl_fall  (scl_fall_evt),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  byte_rx #(.DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W)) u_rx (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_rise      (scl_rise_evt),
    .scl_fall      (scl_fall_evt),
    .sda_s         (sda_s),
    .start_evt     (start_evt),
    .stop_evt      (stop_evt),
    .sda_drive_low (sda_drive_low),
    .byte_evt      (byte_evt),
    .byte_data     (byte_data),
    .byte_idx      (byte_idx),
    .ignoring      (ignoring)
  );

  reg_bank #(.SKIP(SKIP_BYTES), .IDX_W(IDX_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_evt  (byte_evt),
    .byte_data (byte_data),
    .byte_idx  (byte_idx),
    .commit    (stop_evt),
    .live      (live)
  );

  assign out_en_a     = live[0];
  assign out_en_b     = live[1];
  assign mode_ctl     = live[2];
  assign freq_sel_eff = pick_freq(live[2], {strap_test, strap_fs1, strap_fs0});
endmodule

// File: rtl/clkgen_ctl_bank_chk.sv
module clkgen_ctl_bank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_drive_low,
  input logic       scl_fall_evt,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       byte_evt,
  input logic       ignoring,
  input logic [7:0] out_en_a,
  input logic [7:0] out_en_b,
  input logic [7:0] mode_ctl
);
  p_hold_until_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_evt |=> ($stable(out_en_a) && $stable(out_en_b) && $stable(mode_ctl)));

  p_skip_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> !sda_drive_low);

  p_ack_after_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> $past(scl_fall_evt));

  p_ack_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_drive_low) |-> $past(scl_fall_evt || start_evt || stop_evt));

  p_no_load_when_skipping_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_evt |-> !ignoring);

  p_start_rearms_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (!sda_drive_low && !ignoring));
endmodule

bind clkgen_ctl_bank clkgen_ctl_bank_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sda_drive_low (sda_drive_low),
  .scl_fall_evt  (scl_fall_evt),
  .start_evt     (start_evt),
  .stop_evt      (stop_evt),
  .byte_evt      (byte_evt),
  .ignoring      (ignoring),
  .out_en_a      (out_en_a),
  .out_en_b      (out_en_b),
  .mode_ctl      (mode_ctl)
);

// File: tb/clkgen_ctl_bank_test.sv
module clkgen_ctl_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam logic [7:0] WR_ADDR = 8'hD2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic strap_test = 1'b0, strap_fs1 = 1'b1, strap_fs0 = 1'b0;
  wire  sda_drive_low;
  wire  sda_bus = sda_m & ~sda_drive_low;
  logic [7:0] out_en_a, out_en_b, mode_ctl;
  logic [2:0] freq_sel_eff;

  int checks = 0;
  int errors = 0;
  bit guard = 1'b1;
  bit done = 1'b0;

  // reference model state
  logic [7:0] exp_a = 8'hFF, exp_b = 8'hFF, exp_m = 8'h7D;
  logic [7:0] pend_v [3];
  bit         pend_f [3];
  logic [7:0] tx_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  clkgen_ctl_bank uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
    .sda_drive_low(sda_drive_low), .strap_test(strap_test),
    .strap_fs1(strap_fs1), .strap_fs0(strap_fs0), .out_en_a(out_en_a),
    .out_en_b(out_en_b), .mode_ctl(mode_ctl), .freq_sel_eff(freq_sel_eff)
  );

  function automatic logic [2:0] model_freq();
    if (exp_m[1]) return {exp_m[6], exp_m[5], exp_m[4]};
    return {strap_test, strap_fs1, strap_fs0};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // every-clock comparison against the model (R7 hold, R9 mux)
  always @(negedge clk) begin
    if (rst_n && !guard && !done) begin
      check({out_en_a, out_en_b, mode_ctl} === {exp_a, exp_b, exp_m}, "R7",
            "registers vs model", {out_en_a, out_en_b, mode_ctl}, {exp_a, exp_b, exp_m});
      check(freq_sel_eff === model_freq(), "R9", "freq_sel_eff", freq_sel_eff, model_freq());
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_clear();
    for (int i = 0; i < 3; i++) pend_f[i] = 1'b0;
  endtask

  task automatic model_byte(input int k, input logic [7:0] v);
    if (k >= 4 && k <= 6) begin
      pend_v[k-4] = v;
      pend_f[k-4] = 1'b1;
    end
  endtask

  task automatic model_commit();
    if (pend_f[0]) exp_a = pend_v[0];
    if (pend_f[1]) exp_b = pend_v[1];
    if (pend_f[2]) exp_m = pend_v[2];
    model_clear();
  endtask

  task automatic bus_start();
    sda_m = 1'b0; hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic bus_restart();
    sda_m = 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q);
    sda_m = 1'b0; hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(Q);
    scl_m = 1'b1; hold(Q);
    sda_m = 1'b1;
    guard = 1'b1;
    hold(Q);
    model_commit();
    guard = 1'b0;
    hold(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; hold(Q);
    scl_m = 1'b1; hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack_bit);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q/2);
    ack_bit = sda_bus;
    hold(Q - Q/2);
    scl_m = 1'b0; hold(Q);
  endtask

  // address phase plus the bytes in tx_q; returns after the last byte, before STOP
  task automatic addr_and_data(input logic [7:0] addr, input bit want_ack,
                               input int first_idx);
    logic a;
    send_byte(addr, a);
    if (want_ack) check(a === 1'b0, "R2", "address acknowledge", a, 0);
    else          check(a === 1'b1, "R3", "address not acknowledged", a, 1);
    for (int i = 0; i < tx_q.size(); i++) begin
      send_byte(tx_q[i], a);
      if (want_ack) begin
        check(a === 1'b0, "R4", "data byte acknowledge", a, 0);
        model_byte(first_idx + i, tx_q[i]);
      end else begin
        check(a === 1'b1, "R3", "data byte not acknowledged", a, 1);
      end
    end
  endtask

  task automatic q5(input logic [7:0] v0, input logic [7:0] v1, input logic [7:0] v2,
                    input logic [7:0] v3, input logic [7:0] v4);
    tx_q.delete();
    tx_q.push_back(v0); tx_q.push_back(v1); tx_q.push_back(v2);
    tx_q.push_back(v3); tx_q.push_back(v4);
  endtask

  task automatic set_straps(input logic t, input logic f1, input logic f0);
    guard = 1'b1;
    strap_test = t; strap_fs1 = f1; strap_fs0 = f0;
    hold(2);
    guard = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_clear();
    hold(5);
    rst_n = 1'b1;
    hold(2);
    // R1 reset state
    check(out_en_a === 8'hFF, "R1", "out_en_a reset", out_en_a, 8'hFF);
    check(out_en_b === 8'hFF, "R1", "out_en_b reset", out_en_b, 8'hFF);
    check(mode_ctl === 8'h7D, "R1", "mode_ctl reset", mode_ctl, 8'h7D);
    check(sda_drive_low === 1'b0, "R1", "SDA released", sda_drive_low, 0);
    check(freq_sel_eff === 3'b010, "R9", "straps used after reset", freq_sel_eff, 3'b010);
    guard = 1'b0;

    // R6: full write, register-driven frequency select, plus one extra byte
    bus_start();
    q5(8'h11, 8'h22, 8'h33, 8'h44, 8'h5A);
    tx_q.push_back(8'h3C); tx_q.push_back(8'hD2); tx_q.push_back(8'h99);
    addr_and_data(WR_ADDR, 1'b1, 0);
    check(out_en_a === 8'hFF, "R7", "no update before STOP", out_en_a, 8'hFF);
    bus_stop();
    check(out_en_a === 8'h5A, "R6", "byte 4 to out_en_a", out_en_a, 8'h5A);
    check(out_en_b === 8'h3C, "R6", "byte 5 to out_en_b", out_en_b, 8'h3C);
    check(mode_ctl === 8'hD2, "R6", "byte 6 to mode_ctl, byte 7 dropped", mode_ctl, 8'hD2);
    check(freq_sel_eff === 3'b101, "R9", "register frequency select", freq_sel_eff, 3'b101);

    // R5: only the discarded bytes
    bus_start();
    tx_q.delete();
    tx_q.push_back(8'h00); tx_q.push_back(8'h0F); tx_q.push_back(8'hF0); tx_q.push_back(8'hAA);
    addr_and_data(WR_ADDR, 1'b1, 0);
    bus_stop();
    check(out_en_a === 8'h5A, "R5", "bytes 0..3 discarded", out_en_a, 8'h5A);

    // R3: wrong address, then read direction
    bus_start();
    q5(8'h01, 8'h02, 8'h03, 8'h04, 8'h00);
    addr_and_data(8'hD0, 1'b0, 0);
    bus_stop();
    check(out_en_a === 8'h5A, "R3", "wrong address ignored", out_en_a, 8'h5A);
    bus_start();
    tx_q.delete(); tx_q.push_back(8'h00);
    addr_and_data(8'hD3, 1'b0, 0);
    bus_stop();
    check(sda_drive_low === 1'b0, "R3", "read request not acknowledged", sda_drive_low, 0);

    // R8: repeated START restarts the byte count
    bus_start();
    tx_q.delete(); tx_q.push_back(8'hE1); tx_q.push_back(8'hE2);
    addr_and_data(WR_ADDR, 1'b1, 0);
    bus_restart();
    q5(8'hC3, 8'hC4, 8'hC5, 8'hC6, 8'h0F);
    addr_and_data(WR_ADDR, 1'b1, 0);
    bus_stop();
    check(out_en_a === 8'h0F, "R8", "count restarted after repeated START", out_en_a, 8'h0F);
    check(out_en_b === 8'h3C, "R8", "out_en_b untouched", out_en_b, 8'h3C);

    // R7: complete byte 4, then an unfinished byte 5 cut by STOP
    bus_start();
    q5(8'h00, 8'h00, 8'h00, 8'h00, 8'hF0);
    addr_and_data(WR_ADDR, 1'b1, 0);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    bus_stop();
    check(out_en_a === 8'hF0, "R7", "complete byte applied", out_en_a, 8'hF0);
    check(out_en_b === 8'h3C, "R7", "partial byte discarded", out_en_b, 8'h3C);

    // R9: strap-driven selection
    bus_start();
    q5(8'h00, 8'h00, 8'h00, 8'h00, 8'hF0);
    tx_q.push_back(8'h3C); tx_q.push_back(8'h65);
    addr_and_data(WR_ADDR, 1'b1, 0);
    bus_stop();
    check(mode_ctl === 8'h65, "R6", "mode byte loaded", mode_ctl, 8'h65);
    set_straps(1'b1, 1'b0, 1'b1);
    check(freq_sel_eff === 3'b101, "R9", "straps 101 followed", freq_sel_eff, 3'b101);
    set_straps(1'b0, 1'b1, 1'b1);
    check(freq_sel_eff === 3'b011, "R9", "straps 011 followed", freq_sel_eff, 3'b011);
    hold(10);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule